// File: doc/BRIEF.md
# Connection Memory Block-Fill Engine

This block sweeps a selected connection memory and stamps one 4-bit pattern into the top nibble of every word. Software does not have to write each location itself. Software arms a fill through a control write, and that write carries a start bit, the pattern and a target-select bit. The sweep then waits for the next frame pulse. It writes location 0 first and advances one location per channel-slot strobe. When the last location of the chosen memory has been written, hardware clears the busy bit.

Both memories sit inside the block, and each has its own depth parameter. Their low-order bits are never touched by a sweep. Software reaches the memories through a valid/ready word port. That port accepts reads at any time. It withholds ready for writes while a sweep is pending or running, so the sweep always owns the write side. Writing the start bit low aborts a sweep at once. A sticky error bit marks a fill as unreliable. It is set when framing misbehaves during the fill and cleared when the next fill starts.

Top module: `cm_block_fill`

## Requirements
- R1: A control write with `ctl_go`=1 while idle sets `stat_busy` on the next cycle. The same write latches `ctl_pattern` and `ctl_target`, and these appear on `stat_pattern`/`stat_target`.
- R2: A sweep writes the pattern into bits [WIDTH-1:WIDTH-4] of each word and leaves bits [WIDTH-5:0] unchanged.
- R3: Locations 0 to DEPTH-1 of the target are written in ascending order, one per `slot_strobe`, starting after the first `frame_pulse` that follows the start. Strobes before that frame pulse write nothing, and the other memory is not changed. Target 0 has DEPTH0 words and target 1 has DEPTH1 words.
- R4: `stat_busy` falls in the cycle after the strobe that writes the last location.
- R5: A control write with `ctl_go`=0 while busy clears `stat_busy` on the next cycle, and no further locations are written.
- R6: While busy, a word-port request with `mem_we`=1 sees `mem_ready`=0. A read is always accepted, and its data appears with `mem_rvalid` one cycle later. Back-pressure applies only to writes: a write must hold `mem_valid` until `mem_ready` is 1.
- R7: If no slot strobes arrive, `stat_busy` stays high.
- R8: `stat_err` is set by a `frame_pulse` while the sweep is running, or by `frame_err` while busy. It holds until a new start, which clears it.
- R9: A control write with `ctl_go`=1 while busy is ignored: the latched pattern and target do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctl_wr | input | 1 | Control write strobe |
| ctl_go | input | 1 | Start (1) or abort (0) |
| ctl_pattern | input | PAT_W | Fill pattern |
| ctl_target | input | 1 | Memory select |
| stat_busy | output | 1 | Fill pending or running |
| stat_err | output | 1 | Sticky fill-unreliable flag |
| stat_pattern | output | PAT_W | Latched pattern |
| stat_target | output | 1 | Latched target |
| frame_pulse | input | 1 | Frame alignment pulse |
| slot_strobe | input | 1 | One per channel slot |
| frame_err | input | 1 | Framing-error indication |
| mem_valid | input | 1 | Word-port request |
| mem_ready | output | 1 | Word-port accept |
| mem_we | input | 1 | Request is a write |
| mem_target | input | 1 | Memory addressed |
| mem_addr | input | AW | Word address |
| mem_wdata | input | WIDTH | Write data |
| mem_rvalid | output | 1 | Read data valid |
| mem_rdata | output | WIDTH | Read data |

## Verification
Control and framing inputs are driven just after a rising edge and take effect at the next edge. `stat_busy`, `stat_err` and the latched status are therefore checked one cycle after the write, pulse or strobe that moves them. `mem_ready` is combinational and is sampled in the same cycle the request is posed. Read data is checked one cycle after the read is accepted, when `mem_rvalid` is high. Memory contents are read back only after each sweep ends or is aborted, and they are compared with a model built arithmetically from the seed values and the number of strobes issued.

// File: rtl/cm_fill_pkg.sv
package cm_fill_pkg;
  typedef enum logic [1:0] {
    FS_IDLE  = 2'd0,
    FS_ARMED = 2'd1,
    FS_RUN   = 2'd2
  } fill_state_t;

  localparam int NUM_TGT = 2;
endpackage

// File: rtl/cm_fill_seq.sv
module cm_fill_seq
  import cm_fill_pkg::*;
#(
  parameter int DEPTH0 = 2430,
  parameter int DEPTH1 = 512,
  parameter int PAT_W  = 4,
  parameter int AW     = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_go,
  input  logic [PAT_W-1:0] ctl_pat,
  input  logic             ctl_tgt,
  input  logic             frame_pulse,
  input  logic             slot_strobe,
  input  logic             frame_err,
  output logic             busy,
  output logic             err,
  output logic [PAT_W-1:0] pat_q,
  output logic             tgt_q,
  output logic             fill_we,
  output logic [AW-1:0]    fill_addr
);
  localparam logic [AW-1:0] LAST0 = AW'(DEPTH0 - 1);
  localparam logic [AW-1:0] LAST1 = AW'(DEPTH1 - 1);

  fill_state_t   state;
  logic [AW-1:0] addr_q;
  logic [AW-1:0] last_addr;
  logic          abort;
  logic          start;

  assign busy      = (state != FS_IDLE);
  assign abort     = ctl_wr && !ctl_go && busy;
  assign start     = ctl_wr && ctl_go && (state == FS_IDLE);
  assign last_addr = tgt_q ? LAST1 : LAST0;
  assign fill_we   = (state == FS_RUN) && slot_strobe && !abort;
  assign fill_addr = addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= FS_IDLE;
      addr_q <= '0;
      pat_q  <= '0;
      tgt_q  <= 1'b0;
      err    <= 1'b0;
    end else begin
      unique case (state)
        FS_IDLE: begin
          if (start) begin
            state  <= FS_ARMED;
            pat_q  <= ctl_pat;
            tgt_q  <= ctl_tgt;
            addr_q <= '0;
            err    <= 1'b0;
          end
        end
        FS_ARMED: begin
          if (abort) state <= FS_IDLE;
          else if (frame_pulse) begin
            state  <= FS_RUN;
            addr_q <= '0;
          end
        end
        FS_RUN: begin
          if (abort) state <= FS_IDLE;
          else if (slot_strobe) begin
            if (addr_q == last_addr) state <= FS_IDLE;
            else addr_q <= addr_q + 1'b1;
          end
        end
        default: state <= FS_IDLE;
      endcase
      if (busy && frame_err) err <= 1'b1;
      if ((state == FS_RUN) && frame_pulse) err <= 1'b1;
    end
  end

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && (fill_addr == last_addr)) |=> !busy); // R4
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && !ctl_go && busy) |=> (!busy && !fill_we)); // R5
  AST_ADDR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    fill_we |-> (fill_addr <= last_addr)); // R3
  AST_START_CLEARS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && ctl_go && !busy) |=> (busy && !err)); // R8
  AST_PAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> ($stable(pat_q) && $stable(tgt_q))); // R9
endmodule

// File: rtl/cm_fill_bank.sv
module cm_fill_bank #(
  parameter int DEPTH = 512,
  parameter int WIDTH = 16,
  parameter int PAT_W = 4,
  parameter int AW    = 12
) (
  input  logic             clk,
  input  logic             fill_we,
  input  logic [AW-1:0]    fill_addr,
  input  logic [PAT_W-1:0] fill_pat,
  input  logic             cpu_we,
  input  logic             rd_en,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [WIDTH-1:0] cpu_wdata,
  output logic [WIDTH-1:0] rd_data
);
  localparam int BAW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [BAW-1:0]   f_idx;
  logic [BAW-1:0]   c_idx;
  logic             f_ok;
  logic             c_ok;

  assign f_idx = fill_addr[BAW-1:0];
  assign c_idx = cpu_addr[BAW-1:0];
  assign f_ok  = (fill_addr < AW'(DEPTH));
  assign c_ok  = (cpu_addr < AW'(DEPTH));

  always_ff @(posedge clk) begin
    if (fill_we && f_ok)
      mem[f_idx][WIDTH-1 -: PAT_W] <= fill_pat;
    else if (cpu_we && c_ok)
      mem[c_idx] <= cpu_wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rd_data <= c_ok ? mem[c_idx] : '0;
  end
endmodule

// File: rtl/cm_fill_port.sv
module cm_fill_port
  import cm_fill_pkg::*;
(
  input  logic               busy,
  input  logic               mem_valid,
  input  logic               mem_we,
  input  logic               mem_target,
  output logic               mem_ready,
  output logic [NUM_TGT-1:0] cpu_we,
  output logic               rd_en
);
  logic accept;

  assign mem_ready = !(mem_we && busy);
  assign accept    = mem_valid && mem_ready;
  assign rd_en     = accept && !mem_we;

  always_comb begin
    cpu_we = '0;
    cpu_we[mem_target] = accept && mem_we;
  end
endmodule

// File: rtl/cm_block_fill.sv
module cm_block_fill
  import cm_fill_pkg::*;
#(
  parameter int DEPTH0 = 2430,
  parameter int DEPTH1 = 512,
  parameter int WIDTH  = 16,
  parameter int PAT_W  = 4,
  parameter int AW     = $clog2((DEPTH0 > DEPTH1) ? DEPTH0 : DEPTH1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_wr,
  input  logic             ctl_go,
  input  logic [PAT_W-1:0] ctl_pattern,
  input  logic             ctl_target,
  output logic             stat_busy,
  output logic             stat_err,
  output logic [PAT_W-1:0] stat_pattern,
  output logic             stat_target,
  input  logic             frame_pulse,
  input  logic             slot_strobe,
  input  logic             frame_err,
  input  logic             mem_valid,
  output logic             mem_ready,
  input  logic             mem_we,
  input  logic             mem_target,
  input  logic [AW-1:0]    mem_addr,
  input  logic [WIDTH-1:0] mem_wdata,
  output logic             mem_rvalid,
  output logic [WIDTH-1:0] mem_rdata
);
  logic               fill_we;
  logic [AW-1:0]      fill_addr;
  logic [NUM_TGT-1:0] cpu_we;
  logic               rd_en;
  logic [WIDTH-1:0]   bank_rd [NUM_TGT];
  logic               rsel_q;

  cm_fill_seq #(
    .DEPTH0(DEPTH0), .DEPTH1(DEPTH1), .PAT_W(PAT_W), .AW(AW)
  ) seq_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_go(ctl_go), .ctl_pat(ctl_pattern), .ctl_tgt(ctl_target),
    .frame_pulse(frame_pulse), .slot_strobe(slot_strobe), .frame_err(frame_err),
    .busy(stat_busy), .err(stat_err), .pat_q(stat_pattern), .tgt_q(stat_target),
    .fill_we(fill_we), .fill_addr(fill_addr)
  );

  cm_fill_port port_i (
    .busy(stat_busy), .mem_valid(mem_valid), .mem_we(mem_we),
    .mem_target(mem_target), .mem_ready(mem_ready), .cpu_we(cpu_we), .rd_en(rd_en)
  );

  for (genvar g = 0; g < NUM_TGT; g++) begin : g_bank
    localparam int BDEPTH = (g == 0) ? DEPTH0 : DEPTH1;
    logic bank_fill_we;
    assign bank_fill_we = fill_we && (stat_target == 1'(g));

    cm_fill_bank #(
      .DEPTH(BDEPTH), .WIDTH(WIDTH), .PAT_W(PAT_W), .AW(AW)
    ) bank_i (
      .clk(clk),
      .fill_we(bank_fill_we), .fill_addr(fill_addr), .fill_pat(stat_pattern),
      .cpu_we(cpu_we[g]), .rd_en(rd_en && (mem_target == 1'(g))),
      .cpu_addr(mem_addr), .cpu_wdata(mem_wdata), .rd_data(bank_rd[g])
    );

    AST_NO_WR_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
      !(bank_fill_we && cpu_we[g])); // R6
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_rvalid <= 1'b0;
      rsel_q     <= 1'b0;
    end else begin
      mem_rvalid <= rd_en;
      if (rd_en) rsel_q <= mem_target;
    end
  end

  assign mem_rdata = bank_rd[rsel_q];

  AST_NO_CPU_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    stat_busy |-> (cpu_we == '0)); // R6
  AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_we) |=> mem_rvalid); // R6
endmodule

// File: tb/cm_block_fill_tb.sv
module cm_block_fill_tb_top;
  localparam int D0 = 20;
  localparam int D1 = 12;
  localparam int W  = 8;
  localparam int P  = 4;
  localparam int AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ctl_wr = 0, ctl_go = 0, ctl_target = 0;
  logic [P-1:0] ctl_pattern = '0;
  logic stat_busy, stat_err, stat_target;
  logic [P-1:0] stat_pattern;
  logic frame_pulse = 0, slot_strobe = 0, frame_err = 0;
  logic mem_valid = 0, mem_we = 0, mem_target = 0;
  logic mem_ready, mem_rvalid;
  logic [AW-1:0] mem_addr = '0;
  logic [W-1:0] mem_wdata = '0, mem_rdata;

  int checks = 0;
  int fails = 0;
  logic [W-1:0] exp0 [D0];
  logic [W-1:0] exp1 [D1];

  always #2 clk = ~clk;

  cm_block_fill #(.DEPTH0(D0), .DEPTH1(D1), .WIDTH(W), .PAT_W(P), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .ctl_wr(ctl_wr), .ctl_go(ctl_go), .ctl_pattern(ctl_pattern), .ctl_target(ctl_target),
    .stat_busy(stat_busy), .stat_err(stat_err), .stat_pattern(stat_pattern),
    .stat_target(stat_target),
    .frame_pulse(frame_pulse), .slot_strobe(slot_strobe), .frame_err(frame_err),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_target(mem_target), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic ctl(input logic go, input logic [P-1:0] pat, input logic tgt);
    ctl_wr = 1; ctl_go = go; ctl_pattern = pat; ctl_target = tgt;
    tick();
    ctl_wr = 0; ctl_go = 0; ctl_pattern = '0; ctl_target = 0;
  endtask

  task automatic frame();
    frame_pulse = 1; tick(); frame_pulse = 0; tick();
  endtask

  task automatic strobe();
    slot_strobe = 1; tick(); slot_strobe = 0; tick();
  endtask

  task automatic cpu_write(input logic t, input int a, input logic [W-1:0] d);
    mem_valid = 1; mem_we = 1; mem_target = t; mem_addr = AW'(a); mem_wdata = d;
    tick();
    mem_valid = 0; mem_we = 0;
  endtask

  task automatic cpu_read(input logic t, input int a, output logic [W-1:0] d);
    mem_valid = 1; mem_we = 0; mem_target = t; mem_addr = AW'(a);
    tick();
    mem_valid = 0;
    chk("R6 rvalid", 32'(mem_rvalid), 32'd1);
    d = mem_rdata;
  endtask

  task automatic verify_all(input string req);
    logic [W-1:0] d;
    for (int a = 0; a < D0; a++) begin cpu_read(0, a, d); chk(req, 32'(d), 32'(exp0[a])); end
    for (int a = 0; a < D1; a++) begin cpu_read(1, a, d); chk(req, 32'(d), 32'(exp1[a])); end
  endtask

  function automatic logic [W-1:0] stamp(input logic [W-1:0] v, input logic [P-1:0] p);
    return {p, v[W-P-1:0]};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] d;
    tick(); tick();
    rst_n = 1; tick();
    chk("R1 reset busy", 32'(stat_busy), 0);
    chk("R8 reset err", 32'(stat_err), 0);
    chk("R6 reset ready", 32'(mem_ready), 1);

    for (int a = 0; a < D0; a++) begin exp0[a] = W'(a * 13 + 9); cpu_write(0, a, exp0[a]); end
    for (int a = 0; a < D1; a++) begin exp1[a] = W'(a * 29 + 86); cpu_write(1, a, exp1[a]); end
    verify_all("R2 seed");

    // Full sweeps over each target with several patterns
    for (int s = 0; s < 3; s++) begin
      logic t;
      logic [P-1:0] p;
      int dep;
      t = s[0];
      p = P'(4'hA + s * 5);
      dep = t ? D1 : D0;
      ctl(1, p, t);
      chk("R1 busy", 32'(stat_busy), 1);
      chk("R1 pattern", 32'(stat_pattern), 32'(p));
      chk("R1 target", 32'(stat_target), 32'(t));
      strobe(); strobe();  // before frame pulse: must write nothing
      verify_all("R3 pre-frame");
      repeat (20) tick();
      chk("R7 busy without strobes", 32'(stat_busy), 1);
      ctl(1, ~p, ~t);
      chk("R9 pattern held", 32'(stat_pattern), 32'(p));
      chk("R9 target held", 32'(stat_target), 32'(t));
      mem_valid = 1; mem_we = 1; #0;
      chk("R6 write held off", 32'(mem_ready), 0);
      mem_valid = 0; mem_we = 0;
      frame();
      for (int i = 0; i < dep; i++) begin
        slot_strobe = 1; tick(); slot_strobe = 0;
        chk("R4 busy during sweep", 32'(stat_busy), (i == dep - 1) ? 0 : 1);
        tick();
      end
      for (int a = 0; a < dep; a++)
        if (t) exp1[a] = stamp(exp1[a], p); else exp0[a] = stamp(exp0[a], p);
      chk("R8 no error", 32'(stat_err), 0);
      verify_all("R2 R3 sweep");
    end

    // Abort after 7 strobes on target 0
    ctl(1, 4'h3, 0);
    frame();
    for (int i = 0; i < 7; i++) strobe();
    ctl(0, 4'h0, 0);
    chk("R5 abort clears busy", 32'(stat_busy), 0);
    for (int i = 0; i < 4; i++) strobe();
    for (int a = 0; a < 7; a++) exp0[a] = stamp(exp0[a], 4'h3);
    verify_all("R5 R3 abort");

    // Frame pulse during sweep sets sticky error
    ctl(1, 4'h6, 1);
    frame();
    for (int i = 0; i < 4; i++) strobe();
    chk("R8 err before", 32'(stat_err), 0);
    frame_pulse = 1; tick(); frame_pulse = 0;
    chk("R8 err on frame", 32'(stat_err), 1);
    tick();
    for (int i = 4; i < D1; i++) strobe();
    chk("R4 done", 32'(stat_busy), 0);
    chk("R8 err sticky", 32'(stat_err), 1);
    for (int a = 0; a < D1; a++) exp1[a] = stamp(exp1[a], 4'h6);
    ctl(1, 4'h1, 1);
    chk("R8 err cleared", 32'(stat_err), 0);
    frame_err = 1; tick(); frame_err = 0;
    chk("R8 err on frame_err", 32'(stat_err), 1);
    ctl(0, 4'h0, 0);
    chk("R5 abort armed", 32'(stat_busy), 0);
    chk("R8 err kept after abort", 32'(stat_err), 1);
    cpu_write(1, 2, 8'h5C); exp1[2] = 8'h5C;
    cpu_read(1, 2, d);
    chk("R6 write after idle", 32'(d), 32'h5C);
    verify_all("R5 final");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule